// File: doc/BRIEF.md
# Special Register Access Decoder

This block sits beside the execute stage of a small 32-bit core and serves the move-to and move-from special-register instructions. It takes a 16-bit register address, built as a group index shifted left by 11 plus a register number inside that group. For a write it steers the data into the matching internal register. For a read it returns the contents of the matching register.

The block holds its own registers:

- a version word
- the exception vector base
- the exception program counter
- the exception effective address
- the exception status
- a 64-bit multiply-accumulate accumulator, reached as two 32-bit halves
- a power-management word
- an interrupt mask and interrupt status pair
- a window of shadow general-register sets

When a read hits no register, the result is the incoming destination value. The instruction therefore leaves its destination unchanged. Address translation arrays and the tick timer share this address space but are handled by other blocks, so their addresses count as unmapped here.

Read data is combinational from the address. Writes take effect on the rising clock edge where the write strobe is high. The interrupt status register is set by an external 32-bit interrupt vector, and software clears it by writing ones. A power-management write that enables doze or sleep raises a halt request to the pipeline for one cycle.

Top module: `sreg_hub`

## Requirements
- R1: Address = group*2048 + number. The exception vector base (group 0 number 11), exception PC (group 0 number 32), exception address (group 0 number 48) and exception status (group 0 number 64) each read back the last value written to them.
- R2: A read of an address that no register decodes returns `dest_in` unchanged. When `rd_en` is low, `rdata` also equals `dest_in`.
- R3: A write to an unmapped address changes no register.
- R4: A read of the version word (group 0 number 0) returns the stored value ANDed with `VER_MASK`. After reset the stored value is `VER_RESET`.
- R5: Group 5 number 1 accesses accumulator bits 31:0 and group 5 number 2 accesses bits 63:32. A write to one half leaves the other half unchanged.
- R6: The interrupt mask (group 9 number 0) is a plain read/write register.
- R7: A write to interrupt status (group 9 number 2) clears every status bit whose data bit is 1 and leaves the other bits unchanged.
- R8: Each `irq_in` bit that is high on a clock edge sets the matching status bit. A set on the same edge as a clearing write wins.
- R9: A write to power management (group 8 number 0) stores the value. If data bit 4 (doze) or bit 5 (sleep) is 1, `halt_req` is high for exactly the one cycle after that write edge. If neither bit is 1, `halt_req` stays low.
- R10: Group 0 numbers 1024 to 1024+SHADOW_SETS*32-1 address the shadow sets. Set = (number-1024)/32 and register = (number-1024)%32. Each entry reads back what was written to it. The number just past the window is unmapped.
- R11: After reset, every register reads 0 except the version word, and `halt_req` is 0. The reset is asynchronous active-low and its release takes effect two clock edges after `rst_n` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Special register address |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| dest_in | input | 32 | Current destination register value |
| irq_in | input | 32 | Interrupt status set vector |
| rdata | output | 32 | Read data |
| halt_req | output | 1 | One-cycle halt request |

## Verification
The bench builds the block with SHADOW_SETS=3 instead of the default 2. This places the end of the shadow window at number 1119, which is not aligned to a power of two. The last entry of the third set and the first number past it can then both be reached, and the window limit has to come from a real compare rather than from dropping address bits. The version mask and the doze and sleep bit positions keep their defaults, so the masked version read and both halt triggers are checked against fixed values.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  localparam int GRP_SHIFT    = 11;
  localparam int SHADOW_BASE  = 1024;
  localparam int SHADOW_REGS  = 32;

  function automatic logic [31:0] sreg_addr(input int grp, input int num);
    return 32'((grp << GRP_SHIFT) + num);
  endfunction

  typedef struct packed {
    logic ver;
    logic evb;
    logic epc;
    logic eea;
    logic esr;
    logic mlo;
    logic mhi;
    logic pwr;
    logic imsk;
    logic ists;
  } sreg_sel_t;

endpackage

// File: rtl/sreg_decode.sv
module sreg_decode
  import sreg_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SHADOW_SETS = 2,
  localparam int SH_ENTRIES = SHADOW_SETS * SHADOW_REGS,
  localparam int SH_IDX_W   = (SH_ENTRIES > 1) ? $clog2(SH_ENTRIES) : 1
) (
  input  logic [ADDR_W-1:0]   addr,
  output sreg_sel_t           sel,
  output logic                sh_hit,
  output logic [SH_IDX_W-1:0] sh_idx,
  output logic                any_hit
);

  localparam logic [ADDR_W-1:0] SH_LO = ADDR_W'(SHADOW_BASE);
  localparam logic [ADDR_W-1:0] SH_HI = ADDR_W'(SHADOW_BASE + SH_ENTRIES);

  logic [ADDR_W-1:0] sh_off;

  always_comb begin
    sel      = '0;
    sel.ver  = (addr == ADDR_W'(sreg_addr(0, 0)));
    sel.evb  = (addr == ADDR_W'(sreg_addr(0, 11)));
    sel.epc  = (addr == ADDR_W'(sreg_addr(0, 32)));
    sel.eea  = (addr == ADDR_W'(sreg_addr(0, 48)));
    sel.esr  = (addr == ADDR_W'(sreg_addr(0, 64)));
    sel.mlo  = (addr == ADDR_W'(sreg_addr(5, 1)));
    sel.mhi  = (addr == ADDR_W'(sreg_addr(5, 2)));
    sel.pwr  = (addr == ADDR_W'(sreg_addr(8, 0)));
    sel.imsk = (addr == ADDR_W'(sreg_addr(9, 0)));
    sel.ists = (addr == ADDR_W'(sreg_addr(9, 2)));
  end

  always_comb begin
    sh_off  = addr - SH_LO;
    sh_hit  = (addr >= SH_LO) && (addr < SH_HI);
    sh_idx  = sh_off[SH_IDX_W-1:0];
    any_hit = (|sel) | sh_hit;
  end

  // at most one named register decodes any address
  always_comb begin
    sel_onehot_chk: assert ($onehot0(sel) && !((|sel) && sh_hit));
  end

endmodule

// File: rtl/sreg_word.sv
module sreg_word #(
  parameter int          W     = 32,
  parameter logic [W-1:0] RESET = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (we) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RESET;
    else        q <= q_nxt;
  end

endmodule

// File: rtl/sreg_shadow.sv
module sreg_shadow #(
  parameter int W       = 32,
  parameter int ENTRIES = 64,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [W-1:0]     wd,
  output logic [W-1:0]     rd
);

  logic [W-1:0] mem [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic hit_w;
    assign hit_w = we && (idx == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mem[i] <= '0;
      else if (hit_w) mem[i] <= wd;
    end
  end

  always_comb begin
    rd = '0;
    if (int'(idx) < ENTRIES) rd = mem[idx];
  end

  // R10
  shadow_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(idx)] == $past(wd)));

endmodule

// File: rtl/sreg_irq.sv
module sreg_irq #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mask_we,
  input  logic         clr_we,
  input  logic [W-1:0] wd,
  input  logic [W-1:0] irq_in,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] stat_q
);

  logic [W-1:0] mask_nxt;
  logic [W-1:0] stat_nxt;
  logic [W-1:0] clr_bits;

  always_comb begin
    mask_nxt = mask_q;
    if (mask_we) mask_nxt = wd;
    clr_bits = clr_we ? wd : '0;
    stat_nxt = (stat_q & ~clr_bits) | irq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      mask_q <= mask_nxt;
      stat_q <= stat_nxt;
    end
  end

  // R6
  mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_q == $past(wd)));

  // R7
  stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && (irq_in == '0)) |=> ((stat_q & $past(wd)) == '0));

  // R8
  stat_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|irq_in) |=> ((stat_q & $past(irq_in)) == $past(irq_in)));

endmodule

// File: rtl/sreg_hub.sv
module sreg_hub
  import sreg_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 32,
  parameter int          SHADOW_SETS = 2,
  parameter logic [31:0] VER_RESET   = 32'h1200_0001,
  parameter logic [31:0] VER_MASK    = 32'hFF00_003F,
  parameter int          DOZE_BIT    = 4,
  parameter int          SLEEP_BIT   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] dest_in,
  input  logic [DATA_W-1:0] irq_in,
  output logic [DATA_W-1:0] rdata,
  output logic              halt_req
);

  localparam int SH_ENTRIES = SHADOW_SETS * SHADOW_REGS;
  localparam int SH_IDX_W   = (SH_ENTRIES > 1) ? $clog2(SH_ENTRIES) : 1;

  // reset release synchronizer
  logic [1:0] rst_sync;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  sreg_sel_t           sel;
  logic                sh_hit;
  logic [SH_IDX_W-1:0] sh_idx;
  logic                any_hit;

  sreg_decode #(.ADDR_W(ADDR_W), .SHADOW_SETS(SHADOW_SETS)) u_dec (
    .addr(addr), .sel(sel), .sh_hit(sh_hit), .sh_idx(sh_idx), .any_hit(any_hit)
  );

  logic [DATA_W-1:0] ver_q, evb_q, epc_q, eea_q, esr_q, mlo_q, mhi_q, pwr_q;
  logic [DATA_W-1:0] imsk_q, ists_q, sh_rd;

  sreg_word #(.W(DATA_W), .RESET(DATA_W'(VER_RESET))) u_ver (
    .clk(clk), .rst_n(rst_core_n), .we(wr_en & sel.ver), .d(wdata), .q(ver_q));
  sreg_word #(.W(DATA_W)) u_evb (
    .clk(clk), .rst_n(rst_core_n), .we(wr_en & sel.evb), .d(wdata), .q(evb_q));
  sreg_word #(.W(DATA_W)) u_epc (
    .clk(clk), .rst_n(rst_core_n), .we(wr_en & sel.epc), .d(wdata), .q(epc_q));
  sreg_word #(.W(DATA_W)) u_eea (
    .clk(clk), .rst_n(rst_core_n), .we(wr_en & sel.eea), .d(wdata), .q(eea_q));
  sreg_word #(.W(DATA_W)) u_esr (
    .clk(clk), .rst_n(rst_core_n), .we(wr_en & sel.esr), .d(wdata), .q(esr_q));
  sreg_word #(.W(DATA_W)) u_mlo (
    .clk(clk), .rst_n(rst_core_n), .we(wr_en & sel.mlo), .d(wdata), .q(mlo_q));
  sreg_word #(.W(DATA_W)) u_mhi (
    .clk(clk), .rst_n(rst_core_n), .we(wr_en & sel.mhi), .d(wdata), .q(mhi_q));
  sreg_word #(.W(DATA_W)) u_pwr (
    .clk(clk), .rst_n(rst_core_n), .we(wr_en & sel.pwr), .d(wdata), .q(pwr_q));

  sreg_irq #(.W(DATA_W)) u_irq (
    .clk(clk), .rst_n(rst_core_n),
    .mask_we(wr_en & sel.imsk), .clr_we(wr_en & sel.ists),
    .wd(wdata), .irq_in(irq_in), .mask_q(imsk_q), .stat_q(ists_q));

  sreg_shadow #(.W(DATA_W), .ENTRIES(SH_ENTRIES)) u_sh (
    .clk(clk), .rst_n(rst_core_n), .we(wr_en & sh_hit),
    .idx(sh_idx), .wd(wdata), .rd(sh_rd));

  // halt request
  logic halt_nxt;
  always_comb begin
    halt_nxt = wr_en && sel.pwr && (wdata[DOZE_BIT] || wdata[SLEEP_BIT]);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) halt_req <= 1'b0;
    else             halt_req <= halt_nxt;
  end

  // read mux
  always_comb begin
    rdata = dest_in;
    if (rd_en) begin
      if (sel.ver)  rdata = ver_q & DATA_W'(VER_MASK);
      if (sel.evb)  rdata = evb_q;
      if (sel.epc)  rdata = epc_q;
      if (sel.eea)  rdata = eea_q;
      if (sel.esr)  rdata = esr_q;
      if (sel.mlo)  rdata = mlo_q;
      if (sel.mhi)  rdata = mhi_q;
      if (sel.pwr)  rdata = pwr_q;
      if (sel.imsk) rdata = imsk_q;
      if (sel.ists) rdata = ists_q;
      if (sh_hit)   rdata = sh_rd;
    end
  end

  // R2
  miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!rd_en || !any_hit) |-> (rdata == dest_in));

  // R5
  mac_lo_iso_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_en && sel.mlo) |=> $stable(mhi_q));

  // R5
  mac_hi_iso_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_en && sel.mhi) |=> $stable(mlo_q));

  // R9
  halt_src_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    halt_req |-> $past(wr_en && sel.pwr));

  // R3
  miss_wr_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (wr_en && !any_hit) |=> ($stable(evb_q) && $stable(imsk_q) && $stable(pwr_q)));

endmodule

// File: tb/sreg_hub_bench.sv
module sreg_hub_bench;

  localparam int SETS = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr;
  logic [31:0] wdata, dest_in, irq_in, rdata;
  logic        wr_en, rd_en, halt_req;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  sreg_hub #(.SHADOW_SETS(SETS)) u_sreg_hub (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .dest_in(dest_in), .irq_in(irq_in), .rdata(rdata),
    .halt_req(halt_req));

  function automatic logic [15:0] ad(input int g, input int n);
    return 16'(g * 2048 + n);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] dst, output logic [31:0] v);
    @(negedge clk);
    addr = a; dest_in = dst; rd_en = 1'b1;
    #1 v = rdata;
    rd_en = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(ad(0, 0), 32'h5555_5555, v);  chk("R11 ver", v, 32'h1200_0001);
    rd(ad(9, 0), 32'h5555_5555, v);  chk("R11 mask", v, 0);
    rd(ad(5, 2), 32'h5555_5555, v);  chk("R11 machi", v, 0);
    rd(ad(0, 1030), 32'h5555_5555, v); chk("R11 shadow", v, 0);
    chk("R11 halt", {31'b0, halt_req}, 0);
  endtask

  task automatic t_plain();
    logic [31:0] v;
    wr(ad(0, 11), 32'hA000_1000);
    wr(ad(0, 32), 32'h0000_2004);
    wr(ad(0, 48), 32'hDEAD_BEEF);
    wr(ad(0, 64), 32'h0000_8001);
    rd(ad(0, 11), 0, v); chk("R1 evbase", v, 32'hA000_1000);
    rd(ad(0, 32), 0, v); chk("R1 epc", v, 32'h0000_2004);
    rd(ad(0, 48), 0, v); chk("R1 eear", v, 32'hDEAD_BEEF);
    rd(ad(0, 64), 0, v); chk("R1 esr", v, 32'h0000_8001);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    rd(ad(1, 512), 32'h1111_2222, v); chk("R2 grp1", v, 32'h1111_2222);
    rd(ad(0, 1), 32'h3333_4444, v);   chk("R2 g0n1", v, 32'h3333_4444);
    rd(ad(5, 3), 32'h0BAD_F00D, v);   chk("R2 g5n3", v, 32'h0BAD_F00D);
    @(negedge clk);
    addr = ad(0, 11); dest_in = 32'h7777_0000; rd_en = 1'b0;
    #1 chk("R2 no strobe", rdata, 32'h7777_0000);
    wr(ad(9, 1), 32'hFFFF_FFFF);
    wr(ad(0, 12), 32'hFFFF_FFFF);
    rd(ad(9, 0), 0, v);  chk("R3 mask kept", v, 0);
    rd(ad(0, 11), 0, v); chk("R3 evbase kept", v, 32'hA000_1000);
    rd(ad(9, 2), 0, v);  chk("R3 stat kept", v, 0);
  endtask

  task automatic t_version();
    logic [31:0] v;
    wr(ad(0, 0), 32'hFFFF_FFFF);
    rd(ad(0, 0), 0, v); chk("R4 masked", v, 32'hFF00_003F);
  endtask

  task automatic t_mac();
    logic [31:0] v;
    wr(ad(5, 1), 32'h89AB_CDEF);
    wr(ad(5, 2), 32'h0123_4567);
    rd(ad(5, 1), 0, v); chk("R5 lo", v, 32'h89AB_CDEF);
    rd(ad(5, 2), 0, v); chk("R5 hi", v, 32'h0123_4567);
    wr(ad(5, 1), 32'h0000_0005);
    rd(ad(5, 2), 0, v); chk("R5 hi kept", v, 32'h0123_4567);
    wr(ad(5, 2), 32'hFFFF_0000);
    rd(ad(5, 1), 0, v); chk("R5 lo kept", v, 32'h0000_0005);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    wr(ad(9, 0), 32'hC3C3_0F0F);
    rd(ad(9, 0), 0, v); chk("R6 mask", v, 32'hC3C3_0F0F);
  endtask

  task automatic t_status();
    logic [31:0] v;
    @(negedge clk); irq_in = 32'h0000_00F0;
    @(negedge clk); irq_in = 0;
    rd(ad(9, 2), 0, v); chk("R8 set", v, 32'h0000_00F0);
    wr(ad(9, 2), 32'h0000_0030);
    rd(ad(9, 2), 0, v); chk("R7 w1c", v, 32'h0000_00C0);
    // set and clear of bit 7 on the same edge: set wins, bit 6 clears
    @(negedge clk);
    addr = ad(9, 2); wdata = 32'h0000_00C0; wr_en = 1'b1; irq_in = 32'h0000_0080;
    @(negedge clk);
    wr_en = 1'b0; irq_in = 0;
    rd(ad(9, 2), 0, v); chk("R8 set wins", v, 32'h0000_0080);
  endtask

  task automatic t_power();
    logic [31:0] v;
    wr(ad(8, 0), 32'h0000_0003);
    chk("R9 no halt", {31'b0, halt_req}, 0);
    rd(ad(8, 0), 0, v); chk("R9 stored", v, 32'h0000_0003);
    wr(ad(8, 0), 32'h0000_0010);
    chk("R9 doze halt", {31'b0, halt_req}, 1);
    @(negedge clk);
    chk("R9 one cycle", {31'b0, halt_req}, 0);
    wr(ad(8, 0), 32'h0000_0020);
    chk("R9 sleep halt", {31'b0, halt_req}, 1);
    @(negedge clk);
    chk("R9 sleep drop", {31'b0, halt_req}, 0);
  endtask

  task automatic t_shadow();
    logic [31:0] v;
    for (int s = 0; s < SETS; s++) begin
      for (int r = 0; r < 32; r += 31)
        wr(ad(0, 1024 + s * 32 + r), 32'h5A00_0000 | 32'(s * 256 + r));
    end
    for (int s = 0; s < SETS; s++) begin
      for (int r = 0; r < 32; r += 31) begin
        rd(ad(0, 1024 + s * 32 + r), 0, v);
        chk("R10 entry", v, 32'h5A00_0000 | 32'(s * 256 + r));
      end
    end
    wr(ad(0, 1024 + SETS * 32), 32'hFFFF_FFFF);
    rd(ad(0, 1024 + SETS * 32), 32'h0000_0ABC, v); chk("R10 past end", v, 32'h0000_0ABC);
    rd(ad(0, 1024 + SETS * 32 - 1), 0, v);
    chk("R10 last kept", v, 32'h5A00_0000 | 32'((SETS - 1) * 256 + 31));
  endtask

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog got=running exp=done");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = 0; wdata = 0; wr_en = 0; rd_en = 0; dest_in = 0; irq_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_plain();
    t_unmapped();
    t_version();
    t_mac();
    t_mask();
    t_status();
    t_power();
    t_shadow();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule